// File: doc/BRIEF.md
# Two-Stage RTC Tick Divider with Subsecond Counter

This block turns a slow real-time clock input into a once-per-second calendar enable. It does this with two programmable dividers in series. The first stage is a small up-counter that produces an intermediate tick. A separate timer can use that tick as a faster timebase. The second stage is a binary down-counter of subseconds, and software can read its value at any time. It moves once per intermediate tick and produces the one-second enable at the point where it wraps.

Both ticks are single-cycle clock enables in the RTC clock domain, and the block derives no clocks. The divider settings are taken from the input pins when the load strobe is high. The same strobe restarts both stages, so a new setting starts a full, clean period. With the reset settings of 127 and 255, an input of 32768 Hz gives exactly one tick per second.

Top module: `rtc_prescaler_top`

## Requirements
- R1: After reset, the settings are first = 127 and second = 255. `subsec_o` reads 255. The first `apre_tick_o` appears in cycle 127 after reset is released, and the first `spre_tick_o` appears in cycle 32767. Cycles are counted from 0, and cycle 0 is the first cycle out of reset.
- R2: The first stage asserts `apre_tick_o` for one cycle in every (first setting + 1) cycles. After a reset or a load, its first tick is in cycle index equal to the first setting.
- R3: On each `apre_tick_o` cycle where `subsec_o` is nonzero, `subsec_o` decrements by exactly 1 at the next edge. In cycles without `apre_tick_o`, `subsec_o` holds its value.
- R4: On an `apre_tick_o` cycle where `subsec_o` is 0, `subsec_o` reloads the second setting at the next edge.
- R5: `spre_tick_o` is high exactly in the cycles where `apre_tick_o` is high and `subsec_o` is 0. Its period is (first + 1) × (second + 1) input cycles.
- R6: With a first setting of 0, `apre_tick_o` is high in every cycle. With both settings at 0, `spre_tick_o` is high in every cycle, which is a division factor of 1.
- R7: `subsec_o` is the 15-bit counter zero-extended to 16 bits, so bit 15 is always 0. With a second setting of 32767, which is the largest value and gives a factor of 2^22 together with a first setting of 127, `subsec_o` starts at 32767.
- R8: When `cfg_load_i` is high at an edge, both settings are captured from the inputs. At that same edge, the first stage clears and `subsec_o` loads the new second setting. Counting restarts from cycle 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RTC input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| async_div_i | input | 7 | First-stage setting (divide by value + 1) |
| sync_div_i | input | 15 | Second-stage setting (divide by value + 1) |
| cfg_load_i | input | 1 | Capture settings and restart both stages |
| apre_tick_o | output | 1 | Intermediate tick enable |
| spre_tick_o | output | 1 | One-second tick enable |
| subsec_o | output | 16 | Live subsecond count, zero-extended |

## Verification
Every port value is a direct function of the registered state, so a wrong first-stage count shows on `apre_tick_o` within one first-stage period. A wrong subsecond value is visible on `subsec_o` in the very next cycle. A missed reload or a wrong decrement also shifts `spre_tick_o`, but only up to a full second-stage period later. For that reason the bench compares `subsec_o` in every cycle rather than relying on the slow tick alone.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;
    localparam int ADIV_W     = 7;
    localparam int SDIV_W     = 15;
    localparam int SS_OUT_W   = 16;
    localparam int ADIV_RESET = 127;
    localparam int SDIV_RESET = 255;
endpackage

// File: rtl/rtc_presc_cfg.sv
module rtc_presc_cfg #(
    parameter int AW    = rtc_presc_pkg::ADIV_W,
    parameter int SW    = rtc_presc_pkg::SDIV_W,
    parameter int A_RST = rtc_presc_pkg::ADIV_RESET,
    parameter int S_RST = rtc_presc_pkg::SDIV_RESET
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [AW-1:0] adiv_i,
    input  logic [SW-1:0] sdiv_i,
    output logic [AW-1:0] adiv_o,
    output logic [SW-1:0] sdiv_o
);
    typedef struct packed {
        logic [AW-1:0] adiv;
        logic [SW-1:0] sdiv;
    } cfg_t;

    localparam cfg_t CFG_RST = '{adiv: AW'(A_RST), sdiv: SW'(S_RST)};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.adiv = adiv_i;
            cfg_d.sdiv = sdiv_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= CFG_RST;
        else         cfg_q <= cfg_d;
    end

    assign adiv_o = cfg_q.adiv;
    assign sdiv_o = cfg_q.sdiv;
endmodule

// File: rtl/rtc_presc_astage.sv
module rtc_presc_astage #(
    parameter int AW = rtc_presc_pkg::ADIV_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [AW-1:0] adiv_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [AW-1:0] cnt;
    } ast_t;

    ast_t st_d, st_q;
    logic at_end;

    assign at_end = (st_q.cnt == adiv_i);

    always_comb begin
        st_d = st_q;
        if (load_i || at_end) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = at_end;
endmodule

// File: rtl/rtc_presc_sstage.sv
module rtc_presc_sstage #(
    parameter int SW    = rtc_presc_pkg::SDIV_W,
    parameter int S_RST = rtc_presc_pkg::SDIV_RESET
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [SW-1:0] load_val_i,
    input  logic [SW-1:0] reload_i,
    input  logic          en_i,
    output logic [SW-1:0] count_o,
    output logic          tick_o
);
    typedef struct packed {
        logic [SW-1:0] ss;
    } sst_t;

    sst_t st_d, st_q;
    logic ss_zero;

    assign ss_zero = (st_q.ss == '0);

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.ss = load_val_i;
        end else if (en_i) begin
            if (ss_zero) st_d.ss = reload_i;
            else         st_d.ss = st_q.ss - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.ss <= SW'(S_RST);
        else         st_q    <= st_d;
    end

    assign count_o = st_q.ss;
    assign tick_o  = en_i && ss_zero;
endmodule

// File: rtl/rtc_prescaler_top.sv
module rtc_prescaler_top #(
    parameter int ADIV_W   = rtc_presc_pkg::ADIV_W,
    parameter int SDIV_W   = rtc_presc_pkg::SDIV_W,
    parameter int SS_OUT_W = rtc_presc_pkg::SS_OUT_W,
    parameter int A_RST    = rtc_presc_pkg::ADIV_RESET,
    parameter int S_RST    = rtc_presc_pkg::SDIV_RESET
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ADIV_W-1:0]   async_div_i,
    input  logic [SDIV_W-1:0]   sync_div_i,
    input  logic                cfg_load_i,
    output logic                apre_tick_o,
    output logic                spre_tick_o,
    output logic [SS_OUT_W-1:0] subsec_o
);
    localparam int PAD_W = SS_OUT_W - SDIV_W;

    logic [ADIV_W-1:0] adiv_q;
    logic [SDIV_W-1:0] sdiv_q;
    logic [SDIV_W-1:0] ss_cnt;
    logic              apre_en;

    rtc_presc_cfg #(
        .AW(ADIV_W), .SW(SDIV_W), .A_RST(A_RST), .S_RST(S_RST)
    ) u_cfg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(cfg_load_i),
        .adiv_i(async_div_i),
        .sdiv_i(sync_div_i),
        .adiv_o(adiv_q),
        .sdiv_o(sdiv_q)
    );

    rtc_presc_astage #(.AW(ADIV_W)) u_astage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(cfg_load_i),
        .adiv_i(adiv_q),
        .tick_o(apre_en)
    );

    rtc_presc_sstage #(.SW(SDIV_W), .S_RST(S_RST)) u_sstage (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (cfg_load_i),
        .load_val_i(sync_div_i),
        .reload_i  (sdiv_q),
        .en_i      (apre_en),
        .count_o   (ss_cnt),
        .tick_o    (spre_tick_o)
    );

    assign apre_tick_o = apre_en;

    generate
        if (PAD_W > 0) begin : g_pad
            assign subsec_o = {{PAD_W{1'b0}}, ss_cnt};
        end else begin : g_nopad
            assign subsec_o = ss_cnt[SS_OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/rtc_presc_chk.sv
module rtc_presc_chk #(
    parameter int ADIV_W   = rtc_presc_pkg::ADIV_W,
    parameter int SDIV_W   = rtc_presc_pkg::SDIV_W,
    parameter int SS_OUT_W = rtc_presc_pkg::SS_OUT_W
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [ADIV_W-1:0]   async_div_i,
    input logic [SDIV_W-1:0]   sync_div_i,
    input logic                cfg_load_i,
    input logic                apre_tick_o,
    input logic                spre_tick_o,
    input logic [SS_OUT_W-1:0] subsec_o,
    input logic [ADIV_W-1:0]   adiv_cfg,
    input logic [SDIV_W-1:0]   sdiv_cfg
);
    logic [ADIV_W-1:0] gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       gap_q <= '0;
        else if (cfg_load_i || apre_tick_o) gap_q <= '0;
        else                               gap_q <= gap_q + 1'b1;
    end

    a_r2_apre_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        apre_tick_o |-> (gap_q == adiv_cfg));

    a_r3_ss_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (apre_tick_o && subsec_o != '0 && !cfg_load_i)
        |=> subsec_o == SS_OUT_W'($past(subsec_o) - 1'b1));

    a_r3_ss_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!apre_tick_o && !cfg_load_i) |=> $stable(subsec_o));

    a_r4_ss_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (spre_tick_o && !cfg_load_i) |=> subsec_o[SDIV_W-1:0] == $past(sdiv_cfg));

    a_r5_spre_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spre_tick_o == (apre_tick_o && subsec_o == '0));

    a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        subsec_o[SS_OUT_W-1:SDIV_W] == '0);

    a_r8_load_ss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_load_i |=> subsec_o[SDIV_W-1:0] == $past(sync_div_i));

    a_r8_load_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_load_i |=> adiv_cfg == $past(async_div_i));
endmodule

bind rtc_prescaler_top rtc_presc_chk #(
    .ADIV_W(ADIV_W), .SDIV_W(SDIV_W), .SS_OUT_W(SS_OUT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .async_div_i(async_div_i),
    .sync_div_i (sync_div_i),
    .cfg_load_i (cfg_load_i),
    .apre_tick_o(apre_tick_o),
    .spre_tick_o(spre_tick_o),
    .subsec_o   (subsec_o),
    .adiv_cfg   (adiv_q),
    .sdiv_cfg   (sdiv_q)
);

// File: tb/rtc_prescaler_top_tb.sv
module rtc_prescaler_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  adiv = '0;
    logic [14:0] sdiv = '0;
    logic        load = 1'b0;
    logic        apre, spre;
    logic [15:0] subsec;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rtc_prescaler_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .async_div_i(adiv), .sync_div_i(sdiv),
        .cfg_load_i(load), .apre_tick_o(apre), .spre_tick_o(spre), .subsec_o(subsec)
    );

    // {first setting, second setting, cycles to walk}
    localparam int NV = 9;
    localparam int VEC [NV][3] = '{
        '{0, 0, 20},      // R6 factor 1
        '{0, 5, 40},      // R6 apre every cycle
        '{3, 0, 40},      // R2 R5
        '{3, 4, 100},     // R3 R4
        '{1, 2, 30},
        '{6, 9, 300},
        '{127, 1, 600},   // R2 widest first stage
        '{2, 32767, 60},  // R7 largest second setting
        '{5, 7, 200}
    };

    // Walk n cycles from cycle 0 (the current negedge) against the ideal model.
    task automatic walk(input int a, input int s, input int n, input string tag);
        bit    ok = 1'b1;
        int    fk = 0, fa = 0, fs = 0, fss = 0, ea = 0, es = 0, ess = 0;
        for (int k = 0; k < n; k++) begin
            int nt  = k / (a + 1);
            int xa  = ((k + 1) % (a + 1) == 0) ? 1 : 0;
            int xss = s - (nt % (s + 1));
            int xs  = (xa == 1 && xss == 0) ? 1 : 0;
            if (ok && (int'(apre) != xa || int'(spre) != xs || int'(subsec) != xss)) begin
                ok = 1'b0; fk = k; fa = int'(apre); fs = int'(spre); fss = int'(subsec);
                ea = xa; es = xs; ess = xss;
            end
            @(negedge clk);
        end
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s a=%0d s=%0d cycle %0d: apre/spre/subsec actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, a, s, fk, fa, fs, fss, ea, es, ess);
        end
    endtask

    task automatic do_load(input int a, input int s);
        adiv = 7'(a);
        sdiv = 15'(s);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int first_apre, first_spre, napre;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(subsec == 16'd255, "R1 reset subsec", int'(subsec), 255);
        check(apre == 1'b0 && spre == 1'b0, "R1 reset ticks", int'(apre) + int'(spre), 0);
        // R1: tick positions from reset, counted at the ports
        first_apre = -1; first_spre = -1; napre = 0;
        for (int k = 0; k < 32768; k++) begin
            if (apre) begin
                napre++;
                if (first_apre < 0) first_apre = k;
            end
            if (spre && first_spre < 0) first_spre = k;
            @(negedge clk);
        end
        check(first_apre == 127, "R1 first apre cycle", first_apre, 127);
        check(first_spre == 32767, "R1 first spre cycle", first_spre, 32767);
        check(napre == 256, "R1 apre count per second", napre, 256);

        // Vector table: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            do_load(VEC[v][0], VEC[v][1]);
            walk(VEC[v][0], VEC[v][1], VEC[v][2], "R2 R3 R4 R5 vector");
        end

        // R8: load mid-period restarts both stages
        do_load(4, 6);
        repeat (13) @(negedge clk);
        do_load(2, 3);
        check(subsec == 16'd3, "R8 subsec after load", int'(subsec), 3);
        walk(2, 3, 50, "R8 restart");

        // R7: largest second setting, bit 15 clear
        do_load(0, 32767);
        check(subsec == 16'd32767, "R7 max subsec", int'(subsec), 32767);
        check(subsec[15] == 1'b0, "R7 zero extension", int'(subsec[15]), 0);
        walk(0, 32767, 30, "R7 max walk");

        // R1: reset mid-run restores the defaults
        do_load(1, 1);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(subsec == 16'd255, "R1 re-reset subsec", int'(subsec), 255);
        walk(127, 255, 1000, "R1 defaults after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule